// File: doc/BRIEF.md
# Atomic Thread-Enable Set/Clear Unit

This execution-stage unit belongs to the system-control coprocessor of a multithreaded core. It carries out one indivisible instruction. In a single clock edge the instruction copies the thread-control register to a destination general register and forces that register's threads-enable bit to the value of a set/clear field. The thread-control register lives inside the unit at a fixed coprocessor location, so no register address is decoded from the instruction.

Before the operation commits, two gates are checked. If coprocessor access is disabled, a coprocessor-unusable exception naming coprocessor 0 is raised. If access is enabled but the core has no multithreading support, a reserved-instruction exception is raised. The first check outranks the second, and neither exception lets any state change. Other threads do not see a new threads-enable value at once. The visible threads-enable output lags the register by `VIS_DLY` cycles, and a barrier input collapses that lag to zero.

Top module: `tctl_bitop_unit`

## Requirements
- R1: After reset the control register holds `CTRL_INIT` with bit `TE_POS` forced to 1, `threads_en_o` is 1, and `done_o`, `rf_we_o` and `exc_valid_o` are 0.
- R2: When an operation commits, on the cycle after `valid_i` the unit drives `rf_we_o`=1, `rf_waddr_o`=`rt_i`, and `rf_wdata_o` equal to the control register value from before the edge.
- R3: A committed operation writes `sc_i` into bit `TE_POS` of the control register (0 clears, 1 sets). The new value shows on `ctrl_q_o` on the cycle after `valid_i`.
- R4: When `rt_i` is 0, `rf_we_o` stays 0. The control register is still modified.
- R5: When `valid_i` arrives with `cop_en_i`=0, on the next cycle `exc_valid_o`=1, `exc_code_o`=11 and `exc_cop_o`=0. `rf_we_o` stays 0 and `ctrl_q_o` is unchanged.
- R6: When `valid_i` arrives with `cop_en_i`=1 and `mt_impl_i`=0, on the next cycle `exc_valid_o`=1, `exc_code_o`=10 and `exc_cop_o`=0. `rf_we_o` stays 0 and `ctrl_q_o` is unchanged.
- R7: When both gates fail, code 11 is reported and never code 10.
- R8: No operation changes any bit of the control register other than `TE_POS`.
- R9: `done_o` is high for exactly one cycle after each cycle with `valid_i`=1, exception or not. Back-to-back operations each see the result of the one before.
- R10: With `barrier_i` low, `threads_en_o` equals the register's TE bit as it stood `VIS_DLY` cycles earlier.
- R11: While `barrier_i` is high, `threads_en_o` equals the current TE bit in the same cycle, and the lag line is reloaded so that no stale value reappears afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation issue strobe |
| rt_i | input | REG_IDX_W | Destination general register index |
| sc_i | input | 1 | 1 sets TE, 0 clears TE |
| cop_en_i | input | 1 | Coprocessor 0 access enabled |
| mt_impl_i | input | 1 | Multithreading implemented |
| barrier_i | input | 1 | Hazard barrier, makes TE visible at once |
| done_o | output | 1 | One-cycle completion pulse |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | REG_IDX_W | Register-file write index |
| rf_wdata_o | output | DATA_W | Old control register value |
| ctrl_q_o | output | DATA_W | Current control register |
| threads_en_o | output | 1 | Threads-enable as seen by other threads |
| exc_valid_o | output | 1 | Exception raised |
| exc_code_o | output | 5 | Exception code (10 reserved, 11 unusable) |
| exc_cop_o | output | 2 | Coprocessor number for unusable exception |

## Verification
The bench attacks the priority case where both gates fail. A design with the checks in the wrong order would report code 10 there. It checks the old-value return on back-to-back operations, where a design that registers the value after the modify would return the new TE bit. Operations to register 0 must still toggle TE, so a design that gates the modify with the write enable is caught. The bench also sweeps `threads_en_o` with the barrier held and then released. A lag line that is not reloaded would replay the stale value one cycle after the barrier drops.

// File: rtl/tctl_bitop_pkg.sv
package tctl_bitop_pkg;

  typedef enum logic [4:0] {
    EXC_NONE = 5'd0,
    EXC_RI   = 5'd10,
    EXC_CPU  = 5'd11
  } exc_code_e;

  typedef struct packed {
    logic      hit;
    exc_code_e code;
    logic [1:0] cop;
  } exc_t;

endpackage

// File: rtl/tctl_exc_check.sv
module tctl_exc_check
  import tctl_bitop_pkg::*;
(
  input  logic cop_en_i,
  input  logic mt_impl_i,
  output exc_t exc_o
);
  // unusable outranks reserved
  always_comb begin
    exc_o = '{hit: 1'b0, code: EXC_NONE, cop: 2'd0};
    if (!cop_en_i) begin
      exc_o.hit  = 1'b1;
      exc_o.code = EXC_CPU;
    end else if (!mt_impl_i) begin
      exc_o.hit  = 1'b1;
      exc_o.code = EXC_RI;
    end
  end
endmodule

// File: rtl/tctl_ctrl_reg.sv
module tctl_ctrl_reg #(
  parameter int unsigned     DATA_W    = 32,
  parameter int unsigned     TE_POS    = 15,
  parameter logic [DATA_W-1:0] CTRL_INIT = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              sc_i,
  output logic [DATA_W-1:0] q_o
);
  localparam logic [DATA_W-1:0] TE_MASK  = {{(DATA_W-1){1'b0}}, 1'b1} << TE_POS;
  localparam logic [DATA_W-1:0] RST_VAL  = CTRL_INIT | TE_MASK;

  logic [DATA_W-1:0] q_d, q_q;

  always_comb begin
    q_d = q_q;
    if (wr_en_i) q_d[TE_POS] = sc_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= RST_VAL;
    else         q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/tctl_vis_delay.sv
module tctl_vis_delay #(
  parameter int unsigned VIS_DLY = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic te_i,
  input  logic barrier_i,
  output logic te_o
);
  generate
    if (VIS_DLY == 0) begin : g_direct
      assign te_o = te_i;
    end else begin : g_line
      logic [VIS_DLY-1:0] line_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          line_q <= '1;
        end else if (barrier_i) begin
          line_q <= {VIS_DLY{te_i}};
        end else begin
          line_q[0] <= te_i;
          for (int i = 1; i < int'(VIS_DLY); i++) line_q[i] <= line_q[i-1];
        end
      end
      assign te_o = barrier_i ? te_i : line_q[VIS_DLY-1];
    end
  endgenerate
endmodule

// File: rtl/tctl_bitop_unit.sv
module tctl_bitop_unit
  import tctl_bitop_pkg::*;
#(
  parameter int unsigned       DATA_W    = 32,
  parameter int unsigned       REG_IDX_W = 5,
  parameter int unsigned       TE_POS    = 15,
  parameter logic [DATA_W-1:0] CTRL_INIT = '0,
  parameter int unsigned       VIS_DLY   = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [REG_IDX_W-1:0] rt_i,
  input  logic                 sc_i,
  input  logic                 cop_en_i,
  input  logic                 mt_impl_i,
  input  logic                 barrier_i,
  output logic                 done_o,
  output logic                 rf_we_o,
  output logic [REG_IDX_W-1:0] rf_waddr_o,
  output logic [DATA_W-1:0]    rf_wdata_o,
  output logic [DATA_W-1:0]    ctrl_q_o,
  output logic                 threads_en_o,
  output logic                 exc_valid_o,
  output logic [4:0]           exc_code_o,
  output logic [1:0]           exc_cop_o
);
  exc_t              exc_d;
  logic              commit;
  logic [DATA_W-1:0] ctrl_q;

  tctl_exc_check u_exc (
    .cop_en_i  (cop_en_i),
    .mt_impl_i (mt_impl_i),
    .exc_o     (exc_d)
  );

  assign commit = valid_i && !exc_d.hit;

  tctl_ctrl_reg #(
    .DATA_W    (DATA_W),
    .TE_POS    (TE_POS),
    .CTRL_INIT (CTRL_INIT)
  ) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (commit),
    .sc_i    (sc_i),
    .q_o     (ctrl_q)
  );

  tctl_vis_delay #(
    .VIS_DLY (VIS_DLY)
  ) u_vis (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .te_i      (ctrl_q[TE_POS]),
    .barrier_i (barrier_i),
    .te_o      (threads_en_o)
  );

  logic                 done_q, we_q, exv_q;
  logic [REG_IDX_W-1:0] waddr_q;
  logic [DATA_W-1:0]    wdata_q;
  logic [4:0]           code_q;
  logic [1:0]           cop_q;

  // old value captured from pre-edge register: read precedes modify
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      we_q    <= 1'b0;
      exv_q   <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
      code_q  <= EXC_NONE;
      cop_q   <= 2'd0;
    end else begin
      done_q <= valid_i;
      we_q   <= commit && (rt_i != '0);
      exv_q  <= valid_i && exc_d.hit;
      code_q <= (valid_i && exc_d.hit) ? exc_d.code : EXC_NONE;
      cop_q  <= (valid_i && exc_d.hit) ? exc_d.cop : 2'd0;
      if (commit) begin
        waddr_q <= rt_i;
        wdata_q <= ctrl_q;
      end
    end
  end

  assign done_o      = done_q;
  assign rf_we_o     = we_q;
  assign rf_waddr_o  = waddr_q;
  assign rf_wdata_o  = wdata_q;
  assign ctrl_q_o    = ctrl_q;
  assign exc_valid_o = exv_q;
  assign exc_code_o  = code_q;
  assign exc_cop_o   = cop_q;
endmodule

// File: rtl/tctl_bitop_chk.sv
module tctl_bitop_chk #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned REG_IDX_W = 5,
  parameter int unsigned TE_POS    = 15
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic [REG_IDX_W-1:0] rt_i,
  input logic                 sc_i,
  input logic                 cop_en_i,
  input logic                 mt_impl_i,
  input logic                 barrier_i,
  input logic                 done_o,
  input logic                 rf_we_o,
  input logic [DATA_W-1:0]    rf_wdata_o,
  input logic [DATA_W-1:0]    ctrl_q_o,
  input logic                 threads_en_o,
  input logic                 exc_valid_o,
  input logic [4:0]           exc_code_o
);
  localparam logic [DATA_W-1:0] KEEP = ~({{(DATA_W-1){1'b0}}, 1'b1} << TE_POS);

  a_r2_old_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && cop_en_i && mt_impl_i && rt_i != '0 |=> rf_we_o && rf_wdata_o == $past(ctrl_q_o));
  a_r3_te_follows_sc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && cop_en_i && mt_impl_i |=> ctrl_q_o[TE_POS] == $past(sc_i));
  a_r4_r0_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && rt_i == '0 |=> !rf_we_o);
  a_r5_cpu_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !cop_en_i |=> exc_valid_o && exc_code_o == 5'd11 && !rf_we_o && $stable(ctrl_q_o));
  a_r6_ri_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && cop_en_i && !mt_impl_i |=> exc_valid_o && exc_code_o == 5'd10 && !rf_we_o && $stable(ctrl_q_o));
  a_r8_other_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $stable(ctrl_q_o & KEEP));
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);
  a_r9_no_spurious_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o);
  a_r11_barrier_now: assert property (@(posedge clk_i) disable iff (!rst_ni)
    barrier_i |-> threads_en_o == ctrl_q_o[TE_POS]);
endmodule

bind tctl_bitop_unit tctl_bitop_chk #(
  .DATA_W    (DATA_W),
  .REG_IDX_W (REG_IDX_W),
  .TE_POS    (TE_POS)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .rt_i         (rt_i),
  .sc_i         (sc_i),
  .cop_en_i     (cop_en_i),
  .mt_impl_i    (mt_impl_i),
  .barrier_i    (barrier_i),
  .done_o       (done_o),
  .rf_we_o      (rf_we_o),
  .rf_wdata_o   (rf_wdata_o),
  .ctrl_q_o     (ctrl_q_o),
  .threads_en_o (threads_en_o),
  .exc_valid_o  (exc_valid_o),
  .exc_code_o   (exc_code_o)
);

// File: tb/tctl_bitop_unit_bench.sv
module tctl_bitop_unit_bench;
  localparam int unsigned DW   = 32;
  localparam int unsigned RW   = 5;
  localparam int unsigned TEP  = 15;
  localparam logic [DW-1:0] INIT = 32'h00A5_0C02;
  localparam int unsigned VD   = 2;
  localparam int WD_LIMIT      = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          valid, sc, cop_en, mt_impl, barrier;
  logic [RW-1:0] rt;
  logic          done, rf_we, threads_en, exc_valid;
  logic [RW-1:0] rf_waddr;
  logic [DW-1:0] rf_wdata, ctrl_q;
  logic [4:0]    exc_code;
  logic [1:0]    exc_cop;

  tctl_bitop_unit #(
    .DATA_W (DW), .REG_IDX_W (RW), .TE_POS (TEP), .CTRL_INIT (INIT), .VIS_DLY (VD)
  ) u_tctl_bitop_unit (
    .clk_i (clk), .rst_ni (rst_n), .valid_i (valid), .rt_i (rt), .sc_i (sc),
    .cop_en_i (cop_en), .mt_impl_i (mt_impl), .barrier_i (barrier),
    .done_o (done), .rf_we_o (rf_we), .rf_waddr_o (rf_waddr), .rf_wdata_o (rf_wdata),
    .ctrl_q_o (ctrl_q), .threads_en_o (threads_en), .exc_valid_o (exc_valid),
    .exc_code_o (exc_code), .exc_cop_o (exc_cop)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // reference model state
  logic [DW-1:0] m_ctrl;
  logic          m_done, m_we, m_exc;
  logic [RW-1:0] m_waddr;
  logic [DW-1:0] m_wdata;
  int            m_code;
  bit            m_line[$];

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_ctrl = INIT | (32'h1 << TEP);
    m_done = 0; m_we = 0; m_exc = 0; m_code = 0; m_waddr = '0; m_wdata = '0;
    m_line.delete();
    for (int i = 0; i < int'(VD); i++) m_line.push_back(1'b1);
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      bit old_te;
      old_te = m_ctrl[TEP];
      if (barrier) begin
        for (int i = 0; i < int'(VD); i++) m_line[i] = old_te;
      end else begin
        m_line.push_front(old_te);
        void'(m_line.pop_back());
      end
      m_done = valid;
      m_we   = 0;
      m_exc  = 0;
      m_code = 0;
      if (valid) begin
        if (!cop_en) begin
          m_exc = 1; m_code = 11;
        end else if (!mt_impl) begin
          m_exc = 1; m_code = 10;
        end else begin
          m_we = (rt != 0);
          m_waddr = rt;
          m_wdata = m_ctrl;
          m_ctrl[TEP] = sc;
        end
      end
    end
  end

  task automatic compare(input string tag);
    bit exp_te;
    exp_te = barrier ? m_ctrl[TEP] : m_line[VD-1];
    chk(ctrl_q == m_ctrl, {tag, " R3/R8 ctrl_q"}, ctrl_q, m_ctrl);
    chk((ctrl_q & ~(32'h1 << TEP)) == (INIT & ~(32'h1 << TEP)), "R8 other bits", ctrl_q, INIT);
    chk(done == m_done, {tag, " R9 done"}, 32'(done), 32'(m_done));
    chk(rf_we == m_we, {tag, " R2/R4 rf_we"}, 32'(rf_we), 32'(m_we));
    if (m_we) begin
      chk(rf_waddr == m_waddr, {tag, " R2 waddr"}, 32'(rf_waddr), 32'(m_waddr));
      chk(rf_wdata == m_wdata, {tag, " R2 wdata"}, rf_wdata, m_wdata);
    end
    chk(exc_valid == m_exc, {tag, " R5/R6 exc_valid"}, 32'(exc_valid), 32'(m_exc));
    if (m_exc) begin
      chk(int'(exc_code) == m_code, {tag, " R5/R6/R7 code"}, 32'(exc_code), 32'(m_code));
      chk(exc_cop == 2'd0, {tag, " R5 cop"}, 32'(exc_cop), 32'd0);
    end
    chk(threads_en == exp_te, barrier ? {tag, " R11 barrier te"} : {tag, " R10 lag te"},
        32'(threads_en), 32'(exp_te));
  endtask

  task automatic idle_in();
    valid = 0; rt = '0; sc = 0; cop_en = 1; mt_impl = 1; barrier = 0;
  endtask

  // drive at negedge-aligned time, compare after next edge
  task automatic op(input bit v, input logic [RW-1:0] r, input bit s,
                    input bit ce, input bit mt, input bit b, input string tag);
    valid = v; rt = r; sc = s; cop_en = ce; mt_impl = mt; barrier = b;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_in();
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ctrl_q == (INIT | (32'h1 << TEP)), "R1 ctrl reset", ctrl_q, INIT | (32'h1 << TEP));
    chk(threads_en == 1'b1, "R1 te reset", 32'(threads_en), 32'd1);
    chk(!done && !rf_we && !exc_valid, "R1 idle outputs", {done, rf_we, exc_valid}, 32'd0);
    rst_n = 1'b1;
    op(0, 0, 0, 1, 1, 0, "idle");
    // R2/R3 clear TE to rt 5, then watch R10 lag
    op(1, 5'd5, 0, 1, 1, 0, "clr");
    repeat (3) op(0, 0, 0, 1, 1, 0, "lag");
    // R4 set TE to r0
    op(1, 5'd0, 1, 1, 1, 0, "r0set");
    op(0, 0, 0, 1, 1, 0, "lag");
    // R5, R6, R7 exceptions
    op(1, 5'd7, 0, 0, 1, 0, "cpu");
    op(1, 5'd7, 0, 1, 0, 0, "ri");
    op(1, 5'd7, 0, 0, 0, 0, "prio");
    // R9 back-to-back
    op(1, 5'd3, 0, 1, 1, 0, "b2b0");
    op(1, 5'd4, 1, 1, 1, 0, "b2b1");
    op(1, 5'd31, 0, 1, 1, 0, "b2b2");
    // R11 barrier held then released
    op(0, 0, 0, 1, 1, 1, "bar");
    op(1, 5'd9, 1, 1, 1, 1, "barop");
    op(0, 0, 0, 1, 1, 1, "bar");
    op(1, 5'd9, 0, 1, 1, 0, "rel");
    op(0, 0, 0, 1, 1, 0, "rel");
    op(0, 0, 0, 1, 1, 0, "rel");
    // mixed traffic
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      r = $urandom;
      op(r[0], r[5:1], r[6], r[7] | r[8], r[9] | r[10], r[11] & r[12], "mix");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule